// File: doc/BRIEF.md
# Credit-Throttled Bitstream Block Streamer

This block feeds a configuration image, supplied as a stream of 32-bit words, into a target's data register. Each accepted word leaves the block as a single write strobe with its data in the same cycle. The stream is split into blocks. In credit mode a block holds `BLOCK_BYTES` bytes. In legacy mode each word is its own block and no flow control applies.

In credit mode the target exposes an 8-bit credit count that runs freely. A new block may begin only while that count differs, modulo 256, from the low byte of the block's own count of blocks sent. If credit is missing, the block waits and samples the credit input again after each poll interval of microsecond ticks. It gives up with a timeout after `TIMEOUT_US` ticks of waiting. If the configuration-error input is high at a failed credit sample, the block aborts at once. Optional error checking samples the same input after every `CHK_BYTES` of cumulative data and once more after the final word. The final word may carry 1 to 3 valid bytes, and the unused upper bytes are written as zero. Each run ends with a one-cycle `done` pulse and a held result code.

Top module: `credit_block_streamer`

## Requirements
- R1: After reset `s_ready`, `wr_en`, `busy` and `done` are low and `result` is 0 (success).
- R2: Every accepted input word produces `wr_en` in the same cycle. When `s_bytes` is 1, 2 or 3, only that many low bytes are passed and the bytes above them are zero. Any other `s_bytes` value passes all four bytes.
- R3: In credit mode (`credit_mode`=1 at start) a block is `BLOCK_BYTES/4` words, or fewer if `s_last` ends it. Before each block the block accepts no data until `(credit - sent) mod 256` is nonzero, where `sent` is the low byte of the sent-block count.
- R4: In legacy mode (`credit_mode`=0 at start) every word is one block and words are accepted without regard to `credit`.
- R5: The sent-block count is cleared at each accepted start and rises by one after the last word of each block.
- R6: While waiting for credit, `credit` is re-sampled only once every `POLL_US` ticks of `us_tick`. A credit change between samples does not raise `s_ready`.
- R7: After `TIMEOUT_US` ticks spent waiting for one block's credit, the run ends with `done` and result 2 (timeout), and no further words are accepted.
- R8: If a credit sample fails while `cfg_err` is high, the run ends on the next edge with result 1 (error) and no further words are accepted.
- R9: With `chk_en`=1 at start, `cfg_err` is sampled in the cycle after a block end where the cumulative byte count is a multiple of `CHK_BYTES`, and after the final word. If it is high, the run ends with result 1 and no further writes.
- R10: A run that completes without error ends with a one-cycle `done` pulse and result 0. This comes one cycle after the final word, or two cycles after it when a check applies.
- R11: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| credit_mode | input | 1 | 1 = credit-throttled blocks, 0 = legacy one-word blocks |
| chk_en | input | 1 | Enable periodic and final error sampling |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block accepts an input word |
| s_data | input | 32 | Input word, byte 0 in bits 7:0 |
| s_bytes | input | 3 | Valid bytes in the word (1..3 partial, else full) |
| s_last | input | 1 | Final word of the image |
| credit | input | 8 | Target's free-running credit count |
| cfg_err | input | 1 | Target's sticky configuration-error flag |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_en | output | 1 | Data register write strobe |
| wr_data | output | 32 | Masked data for the write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 success, 1 error, 2 credit timeout (held until next end) |

## Verification
The assertions assume `s_bytes` is held stable with `s_data` while a word is offered. They also assume `credit` only moves forward, so a failed comparison means the sent count has caught up. The stimulus changes inputs only one delay step after a rising edge. It raises `credit` in single steps mid-wait, and it drops `s_valid` as soon as `busy` falls. The sequences covered are starved credit, error during a wait, and start pulses during a run.

// File: rtl/bsm_pkg.sv
// Package: shared state and result encodings for the block streamer.
package bsm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GATE  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_XFER  = 3'd3,
        ST_CHECK = 3'd4
    } bsm_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_CFG_ERR = 2'd1,
        RES_TIMEOUT = 2'd2
    } bsm_result_e;
endpackage

// File: rtl/bsm_word_mask.sv
// Module: zeroes the bytes of a word above its valid-byte count.
// Assumes: nbytes_i of 1..3 marks a partial word; any other value is full.
module bsm_word_mask (
    input  logic [31:0] data_i,
    input  logic [2:0]  nbytes_i,
    output logic [31:0] data_o,
    output logic [2:0]  nbytes_o
);
    // purpose: normalise the byte count to 1..4
    always_comb begin
        if (nbytes_i >= 3'd1 && nbytes_i <= 3'd3) nbytes_o = nbytes_i;
        else                                      nbytes_o = 3'd4;
    end

    for (genvar lane = 0; lane < 4; lane++) begin : g_lane
        // purpose: pass one byte lane when it lies below the valid count
        assign data_o[lane*8 +: 8] = (nbytes_o > 3'(lane)) ? data_i[lane*8 +: 8] : 8'h00;
    end

    // purpose: a one-byte word must carry nothing above byte 0
    always_comb begin
        if (nbytes_i == 3'd1) AST_MASK_ONE_BYTE: assert (data_o[31:8] == 24'h0); // R2
    end
endmodule

// File: rtl/bsm_credit_gate.sv
// Module: decides whether the target has room for one more block.
// Assumes: credit and sent counts wrap modulo 2**W.
module bsm_credit_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] credit_i,
    input  logic [W-1:0] sent_i,
    output logic         room_o
);
    logic [W-1:0] diff;
    // purpose: modulo difference between credit and blocks sent
    always_comb diff = credit_i - sent_i;
    assign room_o = (diff != '0);
endmodule

// File: rtl/bsm_wait_timer.sv
// Module: poll-interval and total-wait counters in microsecond ticks.
// Assumes: tick_i is a single-cycle pulse; run_i is high only while waiting.
module bsm_wait_timer #(
    parameter int POLL_US    = 10,
    parameter int TIMEOUT_US = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all_i,
    input  logic clr_poll_i,
    input  logic run_i,
    input  logic tick_i,
    output logic poll_due_o,
    output logic expired_o
);
    localparam int POLL_W = $clog2(POLL_US + 1);
    localparam int TMO_W  = $clog2(TIMEOUT_US + 1);

    logic [POLL_W-1:0] poll_q;
    logic [TMO_W-1:0]  wait_q;

    // purpose: advance both counters on each tick spent waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q <= '0;
            wait_q <= '0;
        end else if (clr_all_i) begin
            poll_q <= '0;
            wait_q <= '0;
        end else if (clr_poll_i) begin
            poll_q <= '0;
        end else if (run_i && tick_i) begin
            poll_q <= poll_q + 1'b1;
            wait_q <= wait_q + 1'b1;
        end
    end

    assign poll_due_o = run_i && tick_i && (poll_q == POLL_W'(POLL_US - 1));
    assign expired_o  = run_i && tick_i && (wait_q == TMO_W'(TIMEOUT_US - 1));

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_q <= POLL_W'(POLL_US)); // R6
endmodule

// File: rtl/credit_block_streamer.sv
// Module: streams image words into a data register in credit-gated blocks.
// Assumes: credit never moves backwards during a run; s_data/s_bytes are
// stable while s_valid is high; us_tick is a one-cycle pulse.
module credit_block_streamer #(
    parameter int BLOCK_BYTES = 4096,
    parameter int CHK_BYTES   = 4096,
    parameter int POLL_US     = 10,
    parameter int TIMEOUT_US  = 20000,
    parameter int CNT_W       = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        credit_mode,
    input  logic        chk_en,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic [31:0] s_data,
    input  logic [2:0]  s_bytes,
    input  logic        s_last,
    input  logic [7:0]  credit,
    input  logic        cfg_err,
    input  logic        us_tick,
    output logic        wr_en,
    output logic [31:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result
);
    import bsm_pkg::*;

    localparam int BLOCK_WORDS = BLOCK_BYTES / 4;
    localparam int WCNT_W      = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
    localparam int CHK_LOG     = (CHK_BYTES > 1) ? $clog2(CHK_BYTES) : 1;

    bsm_state_e       st_q, st_d;
    logic [CNT_W-1:0] sent_q, bytes_q, bytes_nxt;
    logic [WCNT_W-1:0] wcnt_q;
    logic             mode_q, chk_q, last_q;
    logic             done_q;
    logic [1:0]       result_q;
    logic             fin;
    bsm_result_e      fin_code;
    logic             room, poll_due, expired;
    logic [2:0]       nb;
    logic             take, blk_end, need_chk;

    bsm_word_mask u_mask (
        .data_i   (s_data),
        .nbytes_i (s_bytes),
        .data_o   (wr_data),
        .nbytes_o (nb)
    );

    bsm_credit_gate #(.W(8)) u_gate (
        .credit_i (credit),
        .sent_i   (sent_q[7:0]),
        .room_o   (room)
    );

    bsm_wait_timer #(.POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  ((st_q == ST_IDLE && start) || (st_q == ST_GATE && room)),
        .clr_poll_i (st_q == ST_GATE && !room),
        .run_i      (st_q == ST_WAIT),
        .tick_i     (us_tick),
        .poll_due_o (poll_due),
        .expired_o  (expired)
    );

    assign s_ready = (st_q == ST_XFER);
    assign take    = s_valid && s_ready;
    assign wr_en   = take;
    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign result  = result_q;

    // purpose: block-end and check decisions for the word being accepted
    always_comb begin
        bytes_nxt = bytes_q + CNT_W'(nb);
        blk_end   = s_last || !mode_q || (wcnt_q == WCNT_W'(BLOCK_WORDS - 1));
        need_chk  = chk_q && (s_last || (bytes_nxt[CHK_LOG-1:0] == '0));
    end

    // purpose: next-state and end-of-run decode
    always_comb begin
        st_d     = st_q;
        fin      = 1'b0;
        fin_code = RES_OK;
        case (st_q)
            ST_IDLE:  if (start) st_d = credit_mode ? ST_GATE : ST_XFER;
            ST_GATE: begin
                if (room)         st_d = ST_XFER;
                else if (cfg_err) begin fin = 1'b1; fin_code = RES_CFG_ERR; end
                else              st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (expired)       begin fin = 1'b1; fin_code = RES_TIMEOUT; end
                else if (poll_due) st_d = ST_GATE;
            end
            ST_XFER: begin
                if (take && blk_end) begin
                    if (need_chk)    st_d = ST_CHECK;
                    else if (s_last) fin = 1'b1;
                    else             st_d = mode_q ? ST_GATE : ST_XFER;
                end
            end
            ST_CHECK: begin
                if (cfg_err)     begin fin = 1'b1; fin_code = RES_CFG_ERR; end
                else if (last_q) fin = 1'b1;
                else             st_d = mode_q ? ST_GATE : ST_XFER;
            end
            default: st_d = ST_IDLE;
        endcase
        if (fin) st_d = ST_IDLE;
    end

    // purpose: state, counters and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            sent_q   <= '0;
            bytes_q  <= '0;
            wcnt_q   <= '0;
            mode_q   <= 1'b0;
            chk_q    <= 1'b0;
            last_q   <= 1'b0;
            done_q   <= 1'b0;
            result_q <= RES_OK;
        end else begin
            st_q   <= st_d;
            done_q <= fin;
            if (fin) result_q <= fin_code;
            if (st_q == ST_IDLE && start) begin
                sent_q  <= '0;
                bytes_q <= '0;
                wcnt_q  <= '0;
                mode_q  <= credit_mode;
                chk_q   <= chk_en;
            end else if (take) begin
                bytes_q <= bytes_nxt;
                last_q  <= s_last;
                if (blk_end) begin
                    wcnt_q <= '0;
                    sent_q <= sent_q + 1'b1;
                end else begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end
        end
    end

    AST_GATE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATE && credit == sent_q[7:0]) |=> (st_q != ST_XFER)); // R3
    AST_SENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_q != $past(sent_q)) |-> (sent_q == $past(sent_q) + 1'b1 || sent_q == '0)); // R5
    AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) && result_q == RES_TIMEOUT |-> $past(st_q) == ST_WAIT); // R7
    AST_NO_WR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !wr_en); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fin) |=> (st_q != ST_IDLE || $past(st_q) == ST_IDLE) && busy); // R11
endmodule

// File: tb/sim_credit_block_streamer.sv
module sim_credit_block_streamer;
    localparam int BLOCK_BYTES = 16;
    localparam int CHK_BYTES   = 32;
    localparam int POLL_US     = 4;
    localparam int TIMEOUT_US  = 40;
    localparam int BW          = BLOCK_BYTES / 4;

    localparam int M_IDLE = 0, M_GATE = 1, M_WAIT = 2, M_XFER = 3, M_CHECK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, credit_mode = 1'b0, chk_en = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [31:0] s_data = '0;
    logic [2:0]  s_bytes = 3'd4;
    logic [7:0]  credit = '0;
    logic        cfg_err = 1'b0, us_tick = 1'b0;
    logic        s_ready, wr_en, busy, done;
    logic [31:0] wr_data;
    logic [1:0]  result;

    credit_block_streamer #(
        .BLOCK_BYTES(BLOCK_BYTES), .CHK_BYTES(CHK_BYTES),
        .POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US), .CNT_W(32)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .credit_mode(credit_mode),
        .chk_en(chk_en), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_bytes(s_bytes), .s_last(s_last), .credit(credit), .cfg_err(cfg_err),
        .us_tick(us_tick), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
        .done(done), .result(result)
    );

    always #5 clk = ~clk;
    always @(posedge clk) begin #1 us_tick = ~us_tick; end

    int vec = 0, miss = 0, cyc = 0, n_wr = 0, n_done = 0;
    int last_res = 0;
    bit started = 0;

    // reference model state
    int m_st = M_IDLE, m_sent = 0, m_bytes = 0, m_wcnt = 0, m_wait = 0, m_poll = 0;
    bit m_mode = 0, m_chk = 0, m_last = 0, m_done = 0;
    int m_res = 0;

    function automatic logic [31:0] masked(input logic [31:0] d, input logic [2:0] n);
        if (n >= 1 && n <= 3) return d & ((32'h1 << (8 * n)) - 1);
        return d;
    endfunction

    function automatic int nbytes(input logic [2:0] n);
        return (n >= 1 && n <= 3) ? int'(n) : 4;
    endfunction

    task automatic m_finish(input int code);
        m_st = M_IDLE; m_done = 1; m_res = code;
    endtask

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_sent = 0; m_bytes = 0; m_wcnt = 0; m_wait = 0;
            m_poll = 0; m_done = 0; m_res = 0; m_last = 0;
            started = 1;
        end else begin
            m_done = 0;
            case (m_st)
                M_IDLE: if (start) begin
                    m_sent = 0; m_bytes = 0; m_wcnt = 0; m_wait = 0; m_poll = 0;
                    m_mode = credit_mode; m_chk = chk_en;
                    m_st = credit_mode ? M_GATE : M_XFER;
                end
                M_GATE: begin
                    if (((int'(credit) - m_sent) % 256 + 256) % 256 != 0) begin
                        m_wait = 0; m_poll = 0; m_st = M_XFER;
                    end else if (cfg_err) m_finish(1);
                    else begin m_poll = 0; m_st = M_WAIT; end
                end
                M_WAIT: if (us_tick) begin
                    m_wait++; m_poll++;
                    if (m_wait == TIMEOUT_US) m_finish(2);
                    else if (m_poll == POLL_US) m_st = M_GATE;
                end
                M_XFER: if (s_valid) begin
                    bit bend;
                    n_wr_model_dummy();
                    m_bytes += nbytes(s_bytes);
                    m_last = s_last;
                    bend = s_last || !m_mode || (m_wcnt == BW - 1);
                    if (bend) begin
                        m_wcnt = 0; m_sent++;
                        if (m_chk && (s_last || (m_bytes % CHK_BYTES == 0))) m_st = M_CHECK;
                        else if (s_last) m_finish(0);
                        else m_st = m_mode ? M_GATE : M_XFER;
                    end else m_wcnt++;
                end
                M_CHECK: begin
                    if (cfg_err) m_finish(1);
                    else if (m_last) m_finish(0);
                    else m_st = m_mode ? M_GATE : M_XFER;
                end
                default: m_st = M_IDLE;
            endcase
        end
    end

    function automatic void n_wr_model_dummy();
    endfunction

    task automatic fail_line(input string req, input string what, input longint act, input longint exp);
        miss++;
        $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    endtask

    // compare every output against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (wr_en) n_wr++;
        if (done) begin n_done++; last_res = int'(result); end
        if (started) begin
            bit e_rdy, e_wr;
            string rq;
            vec++;
            e_rdy = (m_st == M_XFER);
            e_wr  = e_rdy && s_valid;
            rq = (m_st == M_WAIT) ? "R6" : (m_mode ? "R3" : "R4");
            if (s_ready !== e_rdy) fail_line(rq, "s_ready", s_ready, e_rdy);
            if (wr_en !== e_wr) fail_line("R2", "wr_en", wr_en, e_wr);
            if (e_wr && wr_data !== masked(s_data, s_bytes))
                fail_line("R2", "wr_data", wr_data, masked(s_data, s_bytes));
            if (busy !== (m_st != M_IDLE)) fail_line("R11", "busy", busy, m_st != M_IDLE);
            if (done !== m_done) fail_line("R10", "done", done, m_done);
            if (result !== 2'(m_res))
                fail_line(m_res == 2 ? "R7" : (m_res == 1 ? "R8" : "R10"), "result", result, m_res);
        end
        if (cyc > 150000) begin
            miss++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vec++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    task automatic do_start(input bit mode, input bit chk);
        @(posedge clk); #1;
        start = 1; credit_mode = mode; chk_en = chk;
        @(posedge clk); #1;
        start = 0;
        n_wr = 0; n_done = 0;
    endtask

    task automatic send(input int n, input logic [2:0] lastb, input int seed);
        bit gone = 0;
        for (int i = 0; i < n && !gone; i++) begin
            bit acc = 0;
            s_valid = 1;
            s_data  = 32'hC3A50000 ^ (32'(i + seed) * 32'h01030507);
            s_bytes = (i == n - 1) ? lastb : 3'd4;
            s_last  = (i == n - 1);
            while (!acc && !gone) begin
                @(negedge clk);
                if (!busy) gone = 1;
                else if (s_ready) begin acc = 1; @(posedge clk); #1; end
                else begin @(posedge clk); #1; end
            end
        end
        s_valid = 0; s_last = 0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 2000 && n_done == 0; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1", "reset s_ready", s_ready, 0);
        check("R1", "reset busy", busy, 0);
        check("R1", "reset done", done, 0);
        check("R1", "reset result", result, 0);
        check("R1", "reset wr_en", wr_en, 0);

        // legacy: no credit, partial final word of 2 bytes
        credit = 8'd0;
        do_start(0, 0);
        send(5, 3'd2, 1);
        wait_end();
        check("R4", "legacy result", last_res, 0);
        check("R4", "legacy writes", n_wr, 5);

        // credit mode with enough credit; a start pulse mid-run
        credit = 8'd3;
        do_start(1, 0);
        fork
            send(10, 3'd3, 20);
            begin repeat (5) @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0; end
        join
        wait_end();
        check("R11", "run after mid start", last_res, 0);
        check("R3", "credit writes", n_wr, 10);

        // one credit, then credit raised during the wait
        credit = 8'd1;
        do_start(1, 0);
        fork
            send(8, 3'd1, 40);
            begin repeat (30) @(posedge clk); #1 credit = 8'd2; end
        join
        wait_end();
        check("R6", "resume result", last_res, 0);
        check("R6", "resume writes", n_wr, 8);

        // two credits for three blocks: stalls after two blocks
        credit = 8'd2;
        do_start(1, 0);
        send(12, 3'd4, 60);
        wait_end();
        check("R5", "writes before stall", n_wr, 8);
        check("R7", "stall result", last_res, 2);

        // restart clears sent count: one credit again suffices for one block
        credit = 8'd1;
        do_start(1, 0);
        send(4, 3'd4, 80);
        wait_end();
        check("R5", "fresh count result", last_res, 0);

        // no credit and error flag set
        credit = 8'd0; cfg_err = 1;
        do_start(1, 0);
        send(4, 3'd4, 90);
        wait_end();
        check("R8", "error abort result", last_res, 1);
        check("R8", "error abort writes", n_wr, 0);

        // optional checking, clean
        cfg_err = 0;
        do_start(0, 1);
        send(10, 3'd3, 100);
        wait_end();
        check("R9", "checked clean result", last_res, 0);
        check("R9", "checked clean writes", n_wr, 10);

        // optional checking with error: stops at first 32-byte boundary
        cfg_err = 1;
        do_start(0, 1);
        send(12, 3'd4, 120);
        wait_end();
        check("R9", "checked error result", last_res, 1);
        check("R9", "checked error writes", n_wr, 8);
        cfg_err = 0;

        // credit wrap: credit 0 with sent 0 is a stall from the start
        credit = 8'd0;
        do_start(1, 0);
        send(2, 3'd4, 140);
        wait_end();
        check("R3", "zero credit writes", n_wr, 0);
        check("R7", "zero credit result", last_res, 2);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule